// File: doc/BRIEF.md
# Speculative Store Queue with Age-Limited Bypass

This block is a circular store queue for a core that runs ahead of a cache miss under a checkpoint. Stores come in strictly in program order from the nonspeculative or ahead thread. A store may arrive before its address, its data, or both are known. Each entry keeps the address, the data, one "not available" flag for each of them, a speculative flag and the number of the checkpoint that owns it. The queue returns the position it gave the store, called the store's age. A deferred store that executes later uses that age to fill in its address and data.

Loads present an address together with the age of the most recent store ahead of them in program order. The queue searches only from the oldest entry up to that age and reports one of three outcomes: a bypass hit with data, a defer (the nearest matching store has no data yet), or an unknown-address condition (some store in that range has no address yet). Committing a checkpoint makes its stores eligible for memory. Failing a checkpoint discards its stores and every younger store. Only the oldest entry may be written to memory, and only once it is nonspeculative and complete.

The occupancy controller is a three-state machine. SQ_EMPTY goes to SQ_PARTIAL on an insert. SQ_PARTIAL goes to SQ_FULL when the count reaches the depth, and back to SQ_EMPTY when the last entry drains or is flushed. SQ_FULL goes to SQ_PARTIAL on a drain or a flush. Each state holds when nothing moves the count.

Top module: `sq_store_queue`

## Requirements
- R1: An accepted insert writes the entry at the tail with its address, data, both NA flags, speculative flag and checkpoint number. `ins_age` shows the tail position, a pointer with one wrap bit (modulo 2×DEPTH), and it advances by one after each accepted insert.
- R2: When the queue holds DEPTH entries, `ins_valid` raises `ins_overflow` in the same cycle and nothing is inserted, even if a drain happens in that cycle.
- R3: `mem_valid` is high only when the oldest entry exists, is nonspeculative and has both NA flags clear. `mem_valid` with `mem_ready` removes that entry at the next edge.
- R4: `fill_valid` with the age of a queued entry writes that entry's address and data and clears both of its NA flags.
- R5: A load searches only the entries from the oldest one up to and including `ld_age`. A load whose age is not a queued position matches nothing.
- R6: If the youngest searched entry with a known address equal to `ld_addr` has its data available, `ld_hit` is high and `ld_data` carries that data. Otherwise `ld_data` is zero.
- R7: If that youngest matching entry has NA data, `ld_defer` is high and `ld_hit` is low.
- R8: Any searched entry with an NA address raises `ld_unknown`. Such an entry is skipped when the matching store is chosen.
- R9: `cmt_valid` clears the speculative flag of every queued entry of checkpoint `cmt_ckpt`.
- R10: `fl_valid` removes the oldest queued speculative entry of checkpoint `fl_ckpt` and every entry younger than it, so the tail moves back to that entry's position. An insert in the same cycle as `fl_valid` is dropped.
- R11: Load results are combinational from the contents before the edge. A fill, insert or commit in the same cycle affects only later cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Insert a store |
| ins_addr | input | ADDR_W | Store address |
| ins_addr_na | input | 1 | Store address not available |
| ins_data | input | DATA_W | Store data |
| ins_data_na | input | 1 | Store data not available |
| ins_spec | input | 1 | Store belongs to a speculative checkpoint |
| ins_ckpt | input | CKPT_W | Checkpoint number of the store |
| ins_age | output | PTR_W | Age given to the next accepted store |
| ins_overflow | output | 1 | Insert refused, queue full |
| fill_valid | input | 1 | Fill in a deferred store |
| fill_age | input | PTR_W | Age of the store being filled |
| fill_addr | input | ADDR_W | Resolved address |
| fill_data | input | DATA_W | Resolved data |
| ld_valid | input | 1 | Load search request |
| ld_addr | input | ADDR_W | Load address |
| ld_age | input | PTR_W | Age of the youngest store older than the load |
| ld_hit | output | 1 | Bypass data available |
| ld_defer | output | 1 | Matching store has NA data |
| ld_unknown | output | 1 | A searched store has NA address |
| ld_data | output | DATA_W | Bypass data |
| cmt_valid | input | 1 | Commit a checkpoint |
| cmt_ckpt | input | CKPT_W | Checkpoint to commit |
| fl_valid | input | 1 | Fail a checkpoint |
| fl_ckpt | input | CKPT_W | Checkpoint to discard |
| mem_valid | output | 1 | Oldest entry ready to write memory |
| mem_ready | input | 1 | Memory accepts the write |
| mem_addr | output | ADDR_W | Address of the write |
| mem_data | output | DATA_W | Data of the write |

## Verification
A fill and a load search can target the same entry in the same cycle. The search must then see the entry as it was before the edge, and the fill must show only from the next cycle. The bench provokes this with a fill of a store that has NA data while a load matching that store is presented. It expects a defer in that cycle and a hit with the filled data one cycle later. The behavioural model in the bench reaches the same outcome because it evaluates outputs before applying the cycle's updates.

// File: rtl/sq_pkg.sv
package sq_pkg;
    typedef enum logic [1:0] {
        SQ_EMPTY   = 2'd0,
        SQ_PARTIAL = 2'd1,
        SQ_FULL    = 2'd2
    } sq_state_e;
endpackage

// File: rtl/sq_ctrl.sv
module sq_ctrl
    import sq_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int PTR_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             do_ins,
    input  logic             do_drain,
    input  logic             do_flush,
    input  logic [PTR_W-1:0] flush_ptr,
    output logic [PTR_W-1:0] head_ptr,
    output logic [PTR_W-1:0] tail_ptr,
    output logic [PTR_W-1:0] count,
    output logic             full,
    output logic             empty
);
    sq_state_e        state_q, state_n;
    logic [PTR_W-1:0] head_n, tail_n, count_n;

    always_comb begin
        head_n  = head_ptr + PTR_W'(do_drain);
        tail_n  = do_flush ? flush_ptr : tail_ptr + PTR_W'(do_ins);
        count_n = tail_n - head_n;
        if (count_n == '0)
            state_n = SQ_EMPTY;
        else if (count_n == PTR_W'(DEPTH))
            state_n = SQ_FULL;
        else
            state_n = SQ_PARTIAL;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= SQ_EMPTY;
            head_ptr <= '0;
            tail_ptr <= '0;
        end else begin
            state_q  <= state_n;
            head_ptr <= head_n;
            tail_ptr <= tail_n;
        end
    end

    always_comb begin
        count = tail_ptr - head_ptr;
        full  = 1'b0;
        empty = 1'b0;
        unique case (state_q)
            SQ_EMPTY:   empty = 1'b1;
            SQ_PARTIAL: ;
            SQ_FULL:    full  = 1'b1;
            default:    empty = 1'b1;
        endcase
    end
endmodule

// File: rtl/sq_search.sv
module sq_search #(
    parameter int DEPTH  = 64,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64,
    parameter int IDX_W  = 6,
    parameter int PTR_W  = 7
) (
    input  logic                          ld_valid,
    input  logic [ADDR_W-1:0]             ld_addr,
    input  logic [PTR_W-1:0]              ld_age,
    input  logic [PTR_W-1:0]              head_ptr,
    input  logic [PTR_W-1:0]              count,
    input  logic [DEPTH-1:0][ADDR_W-1:0]  addr_q,
    input  logic [DEPTH-1:0][DATA_W-1:0]  data_q,
    input  logic [DEPTH-1:0]              ana_q,
    input  logic [DEPTH-1:0]              dna_q,
    output logic                          ld_hit,
    output logic                          ld_defer,
    output logic                          ld_unknown,
    output logic [DATA_W-1:0]             ld_data
);
    logic [PTR_W-1:0]  ld_off;
    logic              in_win, match, m_dna, unk;
    logic [DATA_W-1:0] m_data;
    logic [IDX_W-1:0]  idx;

    always_comb begin
        ld_off = ld_age - head_ptr;
        in_win = ld_valid && (ld_off < count);
        match  = 1'b0;
        m_dna  = 1'b0;
        m_data = '0;
        unk    = 1'b0;
        idx    = '0;
        for (int k = 0; k < DEPTH; k++) begin
            idx = head_ptr[IDX_W-1:0] + IDX_W'(k);
            if (in_win && (PTR_W'(k) <= ld_off)) begin
                if (ana_q[idx]) begin
                    unk = 1'b1;
                end else if (addr_q[idx] == ld_addr) begin
                    match  = 1'b1;
                    m_dna  = dna_q[idx];
                    m_data = data_q[idx];
                end
            end
        end
        ld_hit     = match && !m_dna;
        ld_defer   = match && m_dna;
        ld_unknown = unk;
        ld_data    = ld_hit ? m_data : '0;
    end
endmodule

// File: rtl/sq_store_queue.sv
module sq_store_queue #(
    parameter  int DEPTH  = 64,
    parameter  int ADDR_W = 32,
    parameter  int DATA_W = 64,
    parameter  int CKPT_W = 2,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int PTR_W  = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ins_valid,
    input  logic [ADDR_W-1:0] ins_addr,
    input  logic              ins_addr_na,
    input  logic [DATA_W-1:0] ins_data,
    input  logic              ins_data_na,
    input  logic              ins_spec,
    input  logic [CKPT_W-1:0] ins_ckpt,
    output logic [PTR_W-1:0]  ins_age,
    output logic              ins_overflow,
    input  logic              fill_valid,
    input  logic [PTR_W-1:0]  fill_age,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [DATA_W-1:0] fill_data,
    input  logic              ld_valid,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [PTR_W-1:0]  ld_age,
    output logic              ld_hit,
    output logic              ld_defer,
    output logic              ld_unknown,
    output logic [DATA_W-1:0] ld_data,
    input  logic              cmt_valid,
    input  logic [CKPT_W-1:0] cmt_ckpt,
    input  logic              fl_valid,
    input  logic [CKPT_W-1:0] fl_ckpt,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data
);
    logic [DEPTH-1:0][ADDR_W-1:0] addr_q;
    logic [DEPTH-1:0][DATA_W-1:0] data_q;
    logic [DEPTH-1:0][CKPT_W-1:0] ckpt_q;
    logic [DEPTH-1:0]             ana_q, dna_q, spec_q, in_q;

    logic [PTR_W-1:0] head_ptr, tail_ptr, count_w, flush_ptr, fl_off, fill_off;
    logic             full_w, empty_w, do_ins, do_drain, do_flush, fl_hit, fill_ok;
    logic [IDX_W-1:0] head_idx, tail_idx, fill_idx, fidx, off_i;

    assign head_idx = head_ptr[IDX_W-1:0];
    assign tail_idx = tail_ptr[IDX_W-1:0];

    // occupancy window of each slot
    always_comb begin
        off_i = '0;
        for (int i = 0; i < DEPTH; i++) begin
            off_i   = IDX_W'(i) - head_idx;
            in_q[i] = ({1'b0, off_i} < count_w);
        end
    end

    // oldest speculative entry of the failing checkpoint
    always_comb begin
        fl_hit = 1'b0;
        fl_off = '0;
        fidx   = '0;
        for (int k = DEPTH - 1; k >= 0; k--) begin
            fidx = head_idx + IDX_W'(k);
            if ((PTR_W'(k) < count_w) && spec_q[fidx] && (ckpt_q[fidx] == fl_ckpt)) begin
                fl_hit = 1'b1;
                fl_off = PTR_W'(k);
            end
        end
    end

    assign flush_ptr    = head_ptr + fl_off;
    assign do_flush     = fl_valid && fl_hit;
    assign do_ins       = ins_valid && !full_w && !fl_valid;
    assign ins_overflow = ins_valid && full_w;
    assign ins_age      = tail_ptr;

    assign fill_off = fill_age - head_ptr;
    assign fill_ok  = fill_valid && (fill_off < count_w);
    assign fill_idx = fill_age[IDX_W-1:0];

    assign mem_valid = !empty_w && !spec_q[head_idx] && !ana_q[head_idx] && !dna_q[head_idx];
    assign mem_addr  = addr_q[head_idx];
    assign mem_data  = data_q[head_idx];
    assign do_drain  = mem_valid && mem_ready;

    sq_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W)) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .do_ins    (do_ins),
        .do_drain  (do_drain),
        .do_flush  (do_flush),
        .flush_ptr (flush_ptr),
        .head_ptr  (head_ptr),
        .tail_ptr  (tail_ptr),
        .count     (count_w),
        .full      (full_w),
        .empty     (empty_w)
    );

    sq_search #(
        .DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .PTR_W(PTR_W)
    ) i_search (
        .ld_valid   (ld_valid),
        .ld_addr    (ld_addr),
        .ld_age     (ld_age),
        .head_ptr   (head_ptr),
        .count      (count_w),
        .addr_q     (addr_q),
        .data_q     (data_q),
        .ana_q      (ana_q),
        .dna_q      (dna_q),
        .ld_hit     (ld_hit),
        .ld_defer   (ld_defer),
        .ld_unknown (ld_unknown),
        .ld_data    (ld_data)
    );

    // entry storage: commit, fill and insert
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
            ckpt_q <= '0;
            ana_q  <= '0;
            dna_q  <= '0;
            spec_q <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (cmt_valid && in_q[i] && (ckpt_q[i] == cmt_ckpt))
                    spec_q[i] <= 1'b0;
                if (fill_ok && (fill_idx == IDX_W'(i))) begin
                    addr_q[i] <= fill_addr;
                    data_q[i] <= fill_data;
                    ana_q[i]  <= 1'b0;
                    dna_q[i]  <= 1'b0;
                end
                if (do_ins && (tail_idx == IDX_W'(i))) begin
                    addr_q[i] <= ins_addr;
                    data_q[i] <= ins_data;
                    ana_q[i]  <= ins_addr_na;
                    dna_q[i]  <= ins_data_na;
                    spec_q[i] <= ins_spec;
                    ckpt_q[i] <= ins_ckpt;
                end
            end
        end
    end
endmodule

// File: rtl/sq_store_queue_chk.sv
module sq_store_queue_chk #(
    parameter int DEPTH = 64,
    parameter int PTR_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ins_valid,
    input logic             ins_overflow,
    input logic [PTR_W-1:0] ins_age,
    input logic             fl_valid,
    input logic             full,
    input logic [PTR_W-1:0] head_ptr,
    input logic [PTR_W-1:0] tail_ptr,
    input logic [PTR_W-1:0] count,
    input logic             mem_valid,
    input logic             mem_ready,
    input logic             ld_valid,
    input logic             ld_hit,
    input logic             ld_defer,
    input logic             ld_unknown
);
    p_age_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid && !full && !fl_valid |=> ins_age == PTR_W'($past(ins_age) + 1'b1));

    p_overflow_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid && full |-> ins_overflow);

    p_overflow_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid && full && !fl_valid |=> tail_ptr == $past(tail_ptr));

    p_no_overfill_r2: assert property (@(posedge clk) disable iff (!rst_n)
        count <= PTR_W'(DEPTH));

    p_drain_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && mem_ready |=> head_ptr == PTR_W'($past(head_ptr) + 1'b1));

    p_head_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_valid && mem_ready) |=> $stable(head_ptr));

    p_empty_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        count == '0 |-> !mem_valid);

    p_hit_defer_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(ld_hit && ld_defer));

    p_idle_search_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_valid |-> !ld_hit && !ld_defer && !ld_unknown);
endmodule

bind sq_store_queue sq_store_queue_chk #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ins_valid    (ins_valid),
    .ins_overflow (ins_overflow),
    .ins_age      (ins_age),
    .fl_valid     (fl_valid),
    .full         (full_w),
    .head_ptr     (head_ptr),
    .tail_ptr     (tail_ptr),
    .count        (count_w),
    .mem_valid    (mem_valid),
    .mem_ready    (mem_ready),
    .ld_valid     (ld_valid),
    .ld_hit       (ld_hit),
    .ld_defer     (ld_defer),
    .ld_unknown   (ld_unknown)
);

// File: tb/test_sq_store_queue.sv
module test_sq_store_queue;
    localparam int CLK_P  = 10;
    localparam int DEPTH  = 8;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;
    localparam int CKPT_W = 2;
    localparam int PTR_W  = $clog2(DEPTH) + 1;
    localparam int MOD    = 2 * DEPTH;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_P/2) clk = ~clk;

    logic              ins_valid, ins_addr_na, ins_data_na, ins_spec;
    logic [ADDR_W-1:0] ins_addr;
    logic [DATA_W-1:0] ins_data;
    logic [CKPT_W-1:0] ins_ckpt;
    logic [PTR_W-1:0]  ins_age;
    logic              ins_overflow;
    logic              fill_valid;
    logic [PTR_W-1:0]  fill_age;
    logic [ADDR_W-1:0] fill_addr;
    logic [DATA_W-1:0] fill_data;
    logic              ld_valid;
    logic [ADDR_W-1:0] ld_addr;
    logic [PTR_W-1:0]  ld_age;
    logic              ld_hit, ld_defer, ld_unknown;
    logic [DATA_W-1:0] ld_data;
    logic              cmt_valid, fl_valid, mem_valid, mem_ready;
    logic [CKPT_W-1:0] cmt_ckpt, fl_ckpt;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_data;

    sq_store_queue #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CKPT_W(CKPT_W)) i_sq_store_queue (
        .clk(clk), .rst_n(rst_n),
        .ins_valid(ins_valid), .ins_addr(ins_addr), .ins_addr_na(ins_addr_na),
        .ins_data(ins_data), .ins_data_na(ins_data_na), .ins_spec(ins_spec),
        .ins_ckpt(ins_ckpt), .ins_age(ins_age), .ins_overflow(ins_overflow),
        .fill_valid(fill_valid), .fill_age(fill_age), .fill_addr(fill_addr), .fill_data(fill_data),
        .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_age(ld_age),
        .ld_hit(ld_hit), .ld_defer(ld_defer), .ld_unknown(ld_unknown), .ld_data(ld_data),
        .cmt_valid(cmt_valid), .cmt_ckpt(cmt_ckpt), .fl_valid(fl_valid), .fl_ckpt(fl_ckpt),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data)
    );

    typedef struct {
        int addr; int data; bit ana; bit dna; bit spec; int ckpt;
    } ent_t;

    ent_t mq[$];
    int   m_head = 0;
    int   m_tail = 0;
    int   nchk = 0;
    int   nerr = 0;

    function automatic int wrap(int v);
        return ((v % MOD) + MOD) % MOD;
    endfunction

    task automatic chk(string req, longint act, longint exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle();
        ins_valid = 0; ins_addr = '0; ins_addr_na = 0; ins_data = '0; ins_data_na = 0;
        ins_spec = 0; ins_ckpt = '0; fill_valid = 0; fill_age = '0; fill_addr = '0;
        fill_data = '0; ld_valid = 0; ld_addr = '0; ld_age = '0; cmt_valid = 0;
        cmt_ckpt = '0; fl_valid = 0; fl_ckpt = '0;
    endtask

    // reference model: outputs from the state before the edge
    task automatic model_compare();
        bit full, mv, m, md, unk;
        int mdat, off;
        full = (mq.size() == DEPTH);
        chk("R2 overflow", ins_overflow, ins_valid && full);
        chk("R1 age", ins_age, m_tail);
        mv = mq.size() > 0 && !mq[0].spec && !mq[0].ana && !mq[0].dna;
        chk("R3 mem_valid", mem_valid, mv);
        if (mv) begin
            chk("R3 mem_addr", mem_addr, mq[0].addr);
            chk("R3 mem_data", mem_data, mq[0].data);
        end
        m = 0; md = 0; unk = 0; mdat = 0;
        if (ld_valid) begin
            off = wrap(int'(ld_age) - m_head);
            if (off < mq.size())
                for (int k = 0; k <= off; k++) begin
                    if (mq[k].ana) unk = 1;
                    else if (mq[k].addr == int'(ld_addr)) begin
                        m = 1; md = mq[k].dna; mdat = mq[k].data;
                    end
                end
        end
        chk("R6 hit", ld_hit, m && !md);
        chk("R7 defer", ld_defer, m && md);
        chk("R8 unknown", ld_unknown, unk);
        chk("R6 data", ld_data, (m && !md) ? mdat : 0);
    endtask

    task automatic model_update();
        bit mv, fh, full;
        int fk, fo;
        ent_t e;
        full = (mq.size() == DEPTH);
        mv = mq.size() > 0 && !mq[0].spec && !mq[0].ana && !mq[0].dna;
        fh = 0; fk = 0;
        if (fl_valid)
            for (int k = mq.size() - 1; k >= 0; k--)
                if (mq[k].spec && mq[k].ckpt == int'(fl_ckpt)) begin fh = 1; fk = k; end
        if (fill_valid) begin
            fo = wrap(int'(fill_age) - m_head);
            if (fo < mq.size()) begin
                mq[fo].addr = int'(fill_addr); mq[fo].data = int'(fill_data);
                mq[fo].ana = 0; mq[fo].dna = 0;
            end
        end
        if (cmt_valid)
            for (int k = 0; k < mq.size(); k++)
                if (mq[k].ckpt == int'(cmt_ckpt)) mq[k].spec = 0;
        if (fh) begin
            while (mq.size() > fk) void'(mq.pop_back());
            m_tail = wrap(m_head + fk);
        end
        if (ins_valid && !full && !fl_valid) begin
            e.addr = int'(ins_addr); e.data = int'(ins_data); e.ana = ins_addr_na;
            e.dna = ins_data_na; e.spec = ins_spec; e.ckpt = int'(ins_ckpt);
            mq.push_back(e);
            m_tail = wrap(m_tail + 1);
        end
        if (mv && mem_ready) begin
            void'(mq.pop_front());
            m_head = wrap(m_head + 1);
        end
    endtask

    // inputs are set after a falling edge; compare, clock, update
    task automatic cycle();
        #2;
        model_compare();
        @(posedge clk);
        model_update();
        @(negedge clk);
    endtask

    task automatic ins(int a, bit ana, int d, bit dna, bit sp, int ck);
        ins_valid = 1; ins_addr = ADDR_W'(a); ins_addr_na = ana; ins_data = DATA_W'(d);
        ins_data_na = dna; ins_spec = sp; ins_ckpt = CKPT_W'(ck);
        cycle();
        idle();
    endtask

    task automatic ldchk(string req, int a, int age, bit eh, bit ed, bit eu, int edat);
        ld_valid = 1; ld_addr = ADDR_W'(a); ld_age = PTR_W'(age);
        #1;
        chk({req, " ld_hit"}, ld_hit, eh);
        chk({req, " ld_defer"}, ld_defer, ed);
        chk({req, " ld_unknown"}, ld_unknown, eu);
        chk({req, " ld_data"}, ld_data, edat);
        cycle();
        idle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog R3 actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        idle();
        mem_ready = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        chk("R1 reset age", ins_age, 0);
        chk("R3 reset mem_valid", mem_valid, 0);
        rst_n = 1;
        @(negedge clk);

        // R1: nonspeculative complete store becomes drainable
        ins(10, 0, 100, 0, 0, 0);
        #1; chk("R3 head ready", mem_valid, 1); chk("R1 age after insert", ins_age, 1);
        ins(20, 0, 0, 1, 1, 1);      // age 1, data NA
        ins(0, 1, 300, 0, 1, 1);     // age 2, address NA
        ins(10, 0, 400, 0, 1, 1);    // age 3

        ldchk("R6 youngest match", 10, 3, 1, 0, 1, 400);
        ldchk("R5 older window", 10, 1, 1, 0, 0, 100);
        ldchk("R7 NA data", 20, 3, 0, 1, 1, 0);
        ldchk("R8 unknown no match", 30, 3, 0, 0, 1, 0);
        ldchk("R5 age outside", 10, 7, 0, 0, 0, 0);

        // R11: fill and load on the same entry in one cycle
        fill_valid = 1; fill_age = 1; fill_addr = 20; fill_data = 222;
        ldchk("R11 same cycle", 20, 3, 0, 1, 1, 0);
        ldchk("R4 filled data", 20, 3, 1, 0, 1, 222);
        fill_valid = 1; fill_age = 2; fill_addr = 50; fill_data = 300;
        cycle(); idle();
        ldchk("R4 address filled", 30, 3, 0, 0, 0, 0);

        // R3: drain stops at speculative entry
        mem_ready = 1;
        cycle();
        #1; chk("R3 spec head blocks", mem_valid, 0);
        cmt_valid = 1; cmt_ckpt = 1;
        cycle(); idle();
        #1; chk("R9 committed head", mem_valid, 1); chk("R9 committed addr", mem_addr, 20);
        repeat (4) cycle();
        #1; chk("R3 drained empty", mem_valid, 0);

        // R10: flush a checkpoint with a simultaneous insert
        mem_ready = 0;
        ins(70, 0, 7, 0, 0, 0);      // age 4
        ins(71, 0, 8, 0, 1, 2);      // age 5
        ins(72, 0, 9, 0, 1, 2);      // age 6
        ins(73, 0, 10, 0, 1, 3);     // age 7
        fl_valid = 1; fl_ckpt = 2;
        ins_valid = 1; ins_addr = 99; ins_data = 1;
        cycle(); idle();
        #1; chk("R10 tail rewound", ins_age, 5);
        ldchk("R10 flushed gone", 72, 6, 0, 0, 0, 0);
        ldchk("R10 survivor", 70, 4, 1, 0, 0, 7);

        // R2: fill to capacity across the index wrap
        for (int n = 0; n < 7; n++) ins(200 + n, 0, 1000 + n, 0, 0, 0);
        #1; chk("R2 full age", ins_age, 12);
        ins(300, 0, 1, 0, 0, 0);
        #1; chk("R2 refused insert", ins_age, 12);
        mem_ready = 1;
        ins_valid = 1; ins_addr = 301;
        #1; chk("R2 overflow with drain", ins_overflow, 1);
        cycle(); idle();
        ldchk("R6 wrapped search", 206, 11, 1, 0, 0, 1006);
        repeat (10) cycle();
        #1; chk("R3 final empty", mem_valid, 0);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule